// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Controller with Completion Handshake

This block drives a two-wire serial bus (SCL/SDA) as a master transmitter, one bus event per software command. Software writes a command word that asks for a START (or repeated START), the transfer of the byte held in the data register, or a STOP. The controller carries out that single action on open-drain line drivers. It then raises a completion flag, posts a status code for the outcome and stays put until software clears the flag.

Clearing the flag is the only way to launch the next action. An interrupt request follows the flag whenever the interrupt-enable bit is set. A programmable divider sets the SCL rate. Both line inputs pass through synchronizers, so the controller can check acknowledge bits, spot a lost arbitration and catch illegal START or STOP edges in the middle of a bit.

Top module: `i2c_byte_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, the status is 0xF8, the IRQ is low and both line drivers are released (scl_oe_o = sda_oe_o = 0).
- R2: The control word layout is bit 7 = completion flag, bit 5 = START request, bit 4 = STOP request, bit 2 = enable and bit 0 = IRQ enable. An action starts only if a control write carries bit 7 = 1 and bit 2 = 1 while the controller is idle. A write with bit 7 = 0 starts nothing.
- R3: Writing 1 to bit 7 clears the completion flag and writing 0 leaves it as it is. While the flag is set and no control write occurs, neither line driver changes.
- R4: irq_o is high exactly when the completion flag and the IRQ-enable bit are both set.
- R5: A START command produces a START condition, leaves SCL driven low, sets the flag and reports status 0x08.
- R6: A byte command issued right after a START sends the data register MSB first, followed by one acknowledge clock. The status is 0x18 if SDA was low in the acknowledge bit and 0x20 if it was high.
- R7: A byte command issued after a byte reports 0x28 if the byte was acknowledged and 0x30 if not.
- R8: A STOP command (bit 4 = 1, bit 5 = 0) drives a STOP condition and then releases both lines. Hardware clears bit 4, the flag stays clear and the status is 0xF8.
- R9: During a byte the SCL period is 16 + 2·D system clocks, where D is the value in the rate register.
- R10: During a byte transfer, SDA changes only while SCL is low.
- R11: If the controller releases SDA for a 1 data bit and samples it low while SCL is high, it releases both lines, sets the flag and reports 0x38.
- R12: If SDA changes while SCL is high within a bit (an illegal START or STOP), the controller releases both lines, sets the flag and reports 0x00.
- R13: With bit 2 clear, both lines are released and commands are ignored. While an action is running, writes to the data register, the rate register and the command bits of the control word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write value |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit next |
| rate_we | input | 1 | Rate register write strobe |
| rate_wdata | input | DIV_W | SCL divider value D |
| ctl_rdata | output | 8 | Control word readback (flag, START, STOP, enable, IRQ enable) |
| dat_rdata | output | 8 | Data register readback |
| status_o | output | 8 | Outcome code of the last action |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The hardest cases to reach are the two fault exits. Both need a second party on SDA at a precise moment inside a bit. For lost arbitration, the bench holds SDA low before a byte whose first bit is 1, so the controller sees a low line in the very first high phase. For a bus error, the bench slows the bit rate, waits for SCL to rise during a 1 bit, lets the controller take its early sample, and then pulls SDA low before the high phase ends.

// File: rtl/i2cb_pkg.sv
// Shared types and constants for the byte-level two-wire controller.
// Assumes a single master transmitter; codes are fixed by the bus protocol.
package i2cb_pkg;

    // engine states: S* = start sequence, P* = stop sequence, B* = byte bits
    typedef enum logic [3:0] {
        EN_IDLE, EN_SA, EN_SB, EN_SC, EN_SD,
        EN_PA, EN_PB, EN_PC, EN_BLO, EN_BHI
    } eng_state_t;

    typedef enum logic [1:0] {
        CMD_START, CMD_STOP, CMD_BYTE
    } cmd_kind_t;

    // control word bit positions
    localparam int CB_FLAG = 7;
    localparam int CB_STA  = 5;
    localparam int CB_STO  = 4;
    localparam int CB_EN   = 2;
    localparam int CB_IE   = 0;

    // outcome codes
    localparam logic [7:0] ST_START     = 8'h08;
    localparam logic [7:0] ST_ADDR_ACK  = 8'h18;
    localparam logic [7:0] ST_ADDR_NACK = 8'h20;
    localparam logic [7:0] ST_DATA_ACK  = 8'h28;
    localparam logic [7:0] ST_DATA_NACK = 8'h30;
    localparam logic [7:0] ST_ARB_LOST  = 8'h38;
    localparam logic [7:0] ST_BUS_ERR   = 8'h00;
    localparam logic [7:0] ST_NONE      = 8'hF8;

    // base half-period length in clocks (period = 2*(BASE_HALF + D))
    localparam int BASE_HALF = 8;

endpackage

// File: rtl/i2cb_rate_gen.sv
// Half-period tick generator. While run is high it emits one tick every
// BASE_HALF + div clocks; it restarts from zero whenever run is low.
// Assumes div is held constant while run is high.
module i2cb_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    import i2cb_pkg::*;

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = CNT_W'(div) + CNT_W'(BASE_HALF) - CNT_W'(1);
    assign tick     = run && (cnt_q == last_cnt);

    // count clocks within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/i2cb_line_sync.sv
// Multi-stage synchronizer for the sampled bus lines. Idle lines read high,
// so the stages reset to 1. Assumes STAGES >= 2.
module i2cb_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh_q;

        // shift the raw level through the stages
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '1;
            end else begin
                sh_q <= {sh_q[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/i2cb_engine.sv
// Bus action engine: runs one START, STOP or 9-clock byte action per cmd_go
// pulse. It pulses done with res_code when a START or byte finishes or a
// fault ends it, and pulses stop_done when a STOP finishes.
// Assumes each phase lasts at least 8 clocks (tick spacing) and that
// cmd_go arrives only while busy is low.
module i2cb_engine (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_go,
    input  i2cb_pkg::cmd_kind_t cmd_kind,
    input  logic [7:0]          byte_in,
    input  logic                tick,
    input  logic                scl_s,
    input  logic                sda_s,
    output logic                busy,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic                done,
    output logic                stop_done,
    output logic [7:0]          res_code
);
    import i2cb_pkg::*;

    eng_state_t st_q;
    logic [7:0] sh_q;
    logic [3:0] bitcnt_q;
    logic       first_q;
    logic [1:0] hi_age_q;
    logic       smp_q;
    logic       addr_ph_q;

    assign busy = (st_q != EN_IDLE);

    // sequence the bus lines through the phases of the current action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= EN_IDLE;
            sh_q      <= '0;
            bitcnt_q  <= '0;
            first_q   <= 1'b0;
            hi_age_q  <= '0;
            smp_q     <= 1'b1;
            addr_ph_q <= 1'b0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            done      <= 1'b0;
            stop_done <= 1'b0;
            res_code  <= ST_NONE;
        end else begin
            done      <= 1'b0;
            stop_done <= 1'b0;
            unique case (st_q)
                EN_IDLE: begin
                    if (cmd_go) begin
                        unique case (cmd_kind)
                            CMD_START: begin
                                st_q   <= EN_SA;
                                sda_oe <= 1'b0;
                            end
                            CMD_STOP: begin
                                st_q    <= EN_PA;
                                scl_oe  <= 1'b1;
                                first_q <= 1'b1;
                            end
                            default: begin
                                st_q     <= EN_BLO;
                                sh_q     <= byte_in;
                                bitcnt_q <= '0;
                                scl_oe   <= 1'b1;
                                first_q  <= 1'b1;
                            end
                        endcase
                    end
                end
                EN_SA: if (tick) begin st_q <= EN_SB; scl_oe <= 1'b0; end
                EN_SB: if (tick) begin st_q <= EN_SC; sda_oe <= 1'b1; end
                EN_SC: if (tick) begin st_q <= EN_SD; scl_oe <= 1'b1; end
                EN_SD: begin
                    if (tick) begin
                        st_q      <= EN_IDLE;
                        done      <= 1'b1;
                        res_code  <= ST_START;
                        addr_ph_q <= 1'b1;
                    end
                end
                EN_PA: begin
                    if (first_q) begin
                        sda_oe  <= 1'b1;
                        first_q <= 1'b0;
                    end
                    if (tick) begin st_q <= EN_PB; scl_oe <= 1'b0; end
                end
                EN_PB: if (tick) begin st_q <= EN_PC; sda_oe <= 1'b0; end
                EN_PC: begin
                    if (tick) begin
                        st_q      <= EN_IDLE;
                        stop_done <= 1'b1;
                        addr_ph_q <= 1'b0;
                    end
                end
                EN_BLO: begin
                    if (first_q) begin
                        sda_oe  <= (bitcnt_q == 4'd8) ? 1'b0 : ~sh_q[7];
                        first_q <= 1'b0;
                    end
                    if (tick) begin
                        st_q     <= EN_BHI;
                        scl_oe   <= 1'b0;
                        hi_age_q <= '0;
                    end
                end
                EN_BHI: begin
                    if (hi_age_q != 2'd3) begin
                        hi_age_q <= hi_age_q + 2'd1;
                    end
                    if (hi_age_q == 2'd2) begin
                        smp_q <= sda_s;
                        if ((bitcnt_q != 4'd8) && !sda_oe && !sda_s) begin
                            st_q      <= EN_IDLE;
                            scl_oe    <= 1'b0;
                            sda_oe    <= 1'b0;
                            done      <= 1'b1;
                            res_code  <= ST_ARB_LOST;
                            addr_ph_q <= 1'b0;
                        end
                    end else if (tick) begin
                        if (scl_s && (sda_s != smp_q)) begin
                            st_q      <= EN_IDLE;
                            scl_oe    <= 1'b0;
                            sda_oe    <= 1'b0;
                            done      <= 1'b1;
                            res_code  <= ST_BUS_ERR;
                            addr_ph_q <= 1'b0;
                        end else if (bitcnt_q == 4'd8) begin
                            st_q      <= EN_IDLE;
                            scl_oe    <= 1'b1;
                            sda_oe    <= 1'b0;
                            done      <= 1'b1;
                            addr_ph_q <= 1'b0;
                            if (addr_ph_q) begin
                                res_code <= smp_q ? ST_ADDR_NACK : ST_ADDR_ACK;
                            end else begin
                                res_code <= smp_q ? ST_DATA_NACK : ST_DATA_ACK;
                            end
                        end else begin
                            st_q     <= EN_BLO;
                            bitcnt_q <= bitcnt_q + 4'd1;
                            sh_q     <= {sh_q[6:0], 1'b0};
                            scl_oe   <= 1'b1;
                            first_q  <= 1'b1;
                        end
                    end
                end
                default: st_q <= EN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_byte_ctrl.sv
// Byte-level two-wire master controller. Holds the control word, data and
// rate registers, launches one engine action per accepted command, and
// latches the completion flag and status code. Assumes software waits for
// the flag (or the STOP bit clearing) before writing the next command.
module i2c_byte_ctrl #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    input  logic             rate_we,
    input  logic [DIV_W-1:0] rate_wdata,
    output logic [7:0]       ctl_rdata,
    output logic [7:0]       dat_rdata,
    output logic [7:0]       status_o,
    output logic             irq_o,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o
);
    import i2cb_pkg::*;

    logic             flag_q, ie_q, en_q, sta_q, sto_q;
    logic [7:0]       status_q, dat_q;
    logic [DIV_W-1:0] div_q;
    logic             busy, tick, cmd_go;
    logic             eng_scl_oe, eng_sda_oe, eng_done, eng_stop_done;
    logic [7:0]       eng_code;
    logic [1:0]       lines_s;
    cmd_kind_t        cmd_kind;

    assign cmd_go = ctl_we && ctl_wdata[CB_FLAG] && ctl_wdata[CB_EN] && !busy;

    // decode which action the command word asks for
    always_comb begin
        if (ctl_wdata[CB_STA]) begin
            cmd_kind = CMD_START;
        end else if (ctl_wdata[CB_STO]) begin
            cmd_kind = CMD_STOP;
        end else begin
            cmd_kind = CMD_BYTE;
        end
    end

    // control word, flag and status bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q   <= 1'b0;
            ie_q     <= 1'b0;
            en_q     <= 1'b0;
            sta_q    <= 1'b0;
            sto_q    <= 1'b0;
            status_q <= ST_NONE;
        end else begin
            if (ctl_we) begin
                ie_q <= ctl_wdata[CB_IE];
                if (!busy) begin
                    en_q  <= ctl_wdata[CB_EN];
                    sta_q <= ctl_wdata[CB_STA];
                    sto_q <= cmd_go && (cmd_kind == CMD_STOP);
                    if (ctl_wdata[CB_FLAG]) begin
                        flag_q <= 1'b0;
                    end
                end
            end
            if (cmd_go) begin
                status_q <= ST_NONE;
            end
            if (eng_done) begin
                flag_q   <= 1'b1;
                status_q <= eng_code;
            end
            if (eng_stop_done) begin
                sto_q    <= 1'b0;
                status_q <= ST_NONE;
            end
        end
    end

    // data and rate registers, frozen while an action runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            div_q <= '0;
        end else if (!busy) begin
            if (dat_we) begin
                dat_q <= dat_wdata;
            end
            if (rate_we) begin
                div_q <= rate_wdata;
            end
        end
    end

    i2cb_line_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s)
    );

    i2cb_rate_gen #(
        .DIV_W (DIV_W)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    i2cb_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_kind  (cmd_kind),
        .byte_in   (dat_q),
        .tick      (tick),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .busy      (busy),
        .scl_oe    (eng_scl_oe),
        .sda_oe    (eng_sda_oe),
        .done      (eng_done),
        .stop_done (eng_stop_done),
        .res_code  (eng_code)
    );

    assign ctl_rdata = {flag_q, 1'b0, sta_q, sto_q, 1'b0, en_q, 1'b0, ie_q};
    assign dat_rdata = dat_q;
    assign status_o  = status_q;
    assign irq_o     = flag_q & ie_q;
    assign scl_oe_o  = eng_scl_oe & en_q;
    assign sda_oe_o  = eng_sda_oe & en_q;
endmodule

// File: rtl/i2c_byte_ctrl_chk.sv
// Property checker for i2c_byte_ctrl, attached by bind. Observes ports only.
module i2c_byte_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [7:0] ctl_rdata,
    input logic [7:0] status_o,
    input logic       irq_o,
    input logic       scl_oe_o,
    input logic       sda_oe_o
);
    // R4: request line tracks flag and enable bit
    a_r4_irq_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (ctl_rdata[7] && ctl_rdata[0]));

    // R3: no bus activity while the flag is pending and untouched
    a_r3_flag_freezes_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[7] && !ctl_we) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));

    // R5: a raised flag always carries an outcome code
    a_r5_flag_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[7]) |-> (status_o != 8'hF8));

    // R8: hardware clearing the STOP bit leaves the bus released
    a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_rdata[4]) && !$past(ctl_we)) |-> (!scl_oe_o && !sda_oe_o));

    // R13: disabled controller drives nothing
    a_r13_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[2] |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind i2c_byte_ctrl i2c_byte_ctrl_chk chk_i (.*);

// File: tb/i2c_byte_ctrl_tb_top.sv
module i2c_byte_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] div;
        logic [7:0] addr;
        logic [7:0] data;
        logic       ack_a;
        logic       ack_d;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd0,  8'hA4, 8'h5A, 1'b1, 1'b1},
        '{8'd3,  8'h3E, 8'hC3, 1'b1, 1'b0},
        '{8'd10, 8'h91, 8'h00, 1'b0, 1'b1},
        '{8'd1,  8'h7F, 8'hFF, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, dat_we = 1'b0, rate_we = 1'b0;
    logic [7:0] ctl_wdata = '0, dat_wdata = '0, rate_wdata = '0;
    logic [7:0] ctl_rdata, dat_rdata, status_o;
    logic       irq_o, scl_oe_o, sda_oe_o;
    logic       scl_line, sda_line;
    logic       slv_pull = 1'b0, inj_pull = 1'b0, slv_ack = 1'b1;
    logic       byte_win = 1'b0;
    logic       finished = 1'b0;
    int         n_chk = 0, n_fail = 0;

    assign scl_line = ~scl_oe_o;
    assign sda_line = ~(sda_oe_o | slv_pull | inj_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .ctl_we (ctl_we), .ctl_wdata (ctl_wdata),
        .dat_we (dat_we), .dat_wdata (dat_wdata),
        .rate_we (rate_we), .rate_wdata (rate_wdata),
        .ctl_rdata (ctl_rdata), .dat_rdata (dat_rdata),
        .status_o (status_o), .irq_o (irq_o),
        .scl_i (scl_line), .sda_i (sda_line),
        .scl_oe_o (scl_oe_o), .sda_oe_o (sda_oe_o)
    );

    // bus-side model: slave receiver, START/STOP spotting, period and R10 monitor
    logic       scl_d = 1'b1, sda_d = 1'b1;
    int         bitn = 0, starts = 0, stops = 0, r10_bad = 0;
    logic [7:0] rx_sh = '0, rx_last = '0;
    int         cyc = 0, fall_t = 0, last_per = 0;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        scl_d <= scl_line;
        sda_d <= sda_line;
        if (byte_win && scl_line && scl_d && (sda_line != sda_d)) r10_bad <= r10_bad + 1;
        if (!scl_line && scl_d) begin
            last_per <= cyc - fall_t;
            fall_t   <= cyc;
        end
        if (scl_line && scl_d && sda_d && !sda_line) begin
            starts <= starts + 1;
            bitn   <= 0;
        end else if (scl_line && scl_d && !sda_d && sda_line) begin
            stops    <= stops + 1;
            bitn     <= 0;
            slv_pull <= 1'b0;
        end else if (scl_line && !scl_d) begin
            if (bitn < 8) rx_sh <= {rx_sh[6:0], sda_line};
            bitn <= bitn + 1;
        end else if (!scl_line && scl_d) begin
            if (bitn == 8) begin
                rx_last <= rx_sh;
                if (slv_ack) slv_pull <= 1'b1;
            end
            if (bitn == 9) begin
                slv_pull <= 1'b0;
                bitn     <= 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wdata = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic wr_rate(input logic [7:0] v);
        @(negedge clk); rate_we = 1'b1; rate_wdata = v;
        @(negedge clk); rate_we = 1'b0;
    endtask

    task automatic wait_flag(input string tag);
        int n = 0;
        while (!ctl_rdata[7] && n < 4000) begin @(negedge clk); n++; end
        chk({tag, " flag raised"}, 32'(ctl_rdata[7]), 32'd1);
    endtask

    task automatic wait_stop(input string tag);
        int n = 0;
        while (ctl_rdata[4] && n < 4000) begin @(negedge clk); n++; end
        chk({tag, " stop bit cleared"}, 32'(ctl_rdata[4]), 32'd0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int st_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ctl", 32'(ctl_rdata), 32'h00);
        chk("R1 status", 32'(status_o), 32'hF8);
        chk("R1 irq", 32'(irq_o), 32'd0);
        chk("R1 lines", 32'({scl_oe_o, sda_oe_o}), 32'd0);

        // table: START, address, data, STOP under several rates and acks
        for (int i = 0; i < 4; i++) begin
            vec_t v = VECS[i];
            wr_rate(v.div);
            wr_ctl(8'hA5);
            wait_flag("R5");
            chk("R5 start code", 32'(status_o), 32'h08);
            chk("R5 scl held low", 32'(scl_oe_o), 32'd1);
            chk("R4 irq with ie", 32'(irq_o), 32'd1);
            wr_ctl(8'h05);
            slv_ack = v.ack_a;
            wr_dat(v.addr);
            byte_win = 1'b1;
            wr_ctl(8'h85);
            wait_flag("R6");
            byte_win = 1'b0;
            chk("R6 addr code", 32'(status_o), v.ack_a ? 32'h18 : 32'h20);
            chk("R6 addr bits MSB first", 32'(rx_last), 32'(v.addr));
            chk("R9 scl period", 32'(last_per), 32'(16 + 2 * int'(v.div)));
            slv_ack = v.ack_d;
            wr_dat(v.data);
            byte_win = 1'b1;
            wr_ctl(8'h85);
            wait_flag("R7");
            byte_win = 1'b0;
            chk("R7 data code", 32'(status_o), v.ack_d ? 32'h28 : 32'h30);
            chk("R7 data bits", 32'(rx_last), 32'(v.data));
            st_before = stops;
            wr_ctl(8'h95);
            wait_stop("R8");
            repeat (4) @(negedge clk);
            chk("R8 flag stays clear", 32'(ctl_rdata[7]), 32'd0);
            chk("R8 status idle", 32'(status_o), 32'hF8);
            chk("R8 lines released", 32'({scl_oe_o, sda_oe_o}), 32'd0);
            chk("R8 stop seen on bus", 32'(stops - st_before), 32'd1);
            repeat (10) @(negedge clk);
        end

        // R2/R3/R4: write without bit 7 leaves flag and lines alone
        slv_ack = 1'b1;
        wr_rate(8'd0);
        wr_ctl(8'hA5);
        wait_flag("R2");
        wr_ctl(8'h25);
        repeat (40) @(negedge clk);
        chk("R3 flag kept on zero write", 32'(ctl_rdata[7]), 32'd1);
        chk("R2 no action, scl still low", 32'(scl_oe_o), 32'd1);
        chk("R2 status unchanged", 32'(status_o), 32'h08);
        wr_ctl(8'h04);
        chk("R4 irq masked", 32'(irq_o), 32'd0);
        chk("R4 flag still set", 32'(ctl_rdata[7]), 32'd1);

        // R13: writes during a running byte are ignored
        wr_dat(8'hC0);
        wr_ctl(8'h84);
        repeat (5) @(negedge clk);
        wr_dat(8'h11);
        wr_ctl(8'h94);
        wait_flag("R13");
        chk("R13 data write ignored when busy", 32'(dat_rdata), 32'hC0);
        chk("R13 byte on bus intact", 32'(rx_last), 32'hC0);
        chk("R13 stop not latched when busy", 32'(ctl_rdata[4]), 32'd0);
        chk("R6 addr ack after start", 32'(status_o), 32'h18);

        // R13: disable releases lines and blocks commands
        wr_ctl(8'h00);
        chk("R13 disable releases scl", 32'(scl_oe_o), 32'd0);
        wr_ctl(8'hA0);
        repeat (100) @(negedge clk);
        chk("R13 disabled start ignored", 32'({scl_oe_o, sda_oe_o}), 32'd0);
        chk("R3 flag cleared by one", 32'(ctl_rdata[7]), 32'd0);
        chk("R13 status kept", 32'(status_o), 32'h18);

        // R11: another master holds SDA low during a 1 bit
        wr_ctl(8'hA5);
        wait_flag("R11");
        inj_pull = 1'b1;
        wr_dat(8'hFF);
        wr_ctl(8'h85);
        wait_flag("R11");
        chk("R11 arbitration code", 32'(status_o), 32'h38);
        chk("R11 lines released", 32'({scl_oe_o, sda_oe_o}), 32'd0);
        inj_pull = 1'b0;
        repeat (20) @(negedge clk);

        // R12: SDA pulled low in the middle of an SCL high phase
        wr_rate(8'd8);
        wr_ctl(8'hA5);
        wait_flag("R12");
        wr_dat(8'hFF);
        wr_ctl(8'h85);
        while (!scl_line) @(negedge clk);
        repeat (6) @(negedge clk);
        inj_pull = 1'b1;
        wait_flag("R12");
        chk("R12 bus error code", 32'(status_o), 32'h00);
        chk("R12 lines released", 32'({scl_oe_o, sda_oe_o}), 32'd0);
        inj_pull = 1'b0;
        repeat (10) @(negedge clk);

        // R10: SDA never moved while SCL was high inside clean bytes
        chk("R10 sda stable in scl high", 32'(r10_bad), 32'd0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule